// File: doc/BRIEF.md
# Two-Program Tape Controller

This block is the finite state machine that drives the head of a small two-track tape machine. On each clock it looks at the pair of symbols under the head, one from the upper track and one from the lower track. In the same cycle it returns the two symbols to write back, the direction to move next, and a halt flag. The tape storage and the head counter sit outside the block. The core applies the outputs and moves the head, and the controller's state register advances on the same clock edge.

A start pulse chooses one of two programs, using the mode input as it stands in that cycle. The first program adds one to the binary number on the lower track and leaves the head on the least significant digit. The second adds the upper-track number into the lower track and leaves the head on the most significant digit. In both programs, digits are written most significant on the left, framed on both sides by non-digit symbols, and the head starts on the least significant digit. Symbol encoding: 2'b00 is digit 0, 2'b01 is digit 1, and 2'b10 and 2'b11 are the two frame symbols. `move_right` set means move right, and clear means move left.

Top module: `tape_prog_ctrl`

## Requirements
- R1: After reset the controller is idle: `halt` and `move_right` are 0, and both write outputs equal the symbols being read, until a start pulse arrives.
- R2: A cycle with `start` high loads the first state of the program picked by `mode` (0 = increment, 1 = add), from any state. Changes of `mode` in later cycles have no effect on the running program.
- R3: Increment, first state: a lower digit 1 (01) is written as 0 (00), the head moves left and the state is kept. A lower digit 0 (00) is written as 1 (01), the head moves right and the return state is entered.
- R4: Increment, first state: a lower frame symbol (10 or 11), meaning every digit was 1, is written back unchanged, the head moves right and the return state is entered.
- R5: Increment, return state: lower digits are written back unchanged while the head moves right. A lower frame symbol is written back, the head moves left and `halt` goes high.
- R6: Add, no-carry state (first state), with the pair given as (upper, lower) digit: (0,0) and (0,1) stay unchanged, (1,0) becomes lower 1, and (1,1) becomes lower 0 and enters the carry state. Every digit step moves left.
- R7: Add, carry state: (0,0) becomes lower 1 and returns to no-carry. (0,1) becomes lower 0 and stays in carry. (1,0) and (1,1) are unchanged and stay in carry. Every digit step moves left.
- R8: Add, either state: an upper frame symbol, whatever the lower symbol, writes both symbols back unchanged, moves the head right and raises `halt`.
- R9: The upper-track symbol is always written back unchanged.
- R10: Once halted, `halt` stays 1, `move_right` is 0 and both symbols are echoed until the next start pulse.
- R11: On a framed 4-digit tape, increment leaves (N+1) mod 16 with the head back on the least significant digit. Add leaves (A+B) mod 16 on the lower track with the head on the most significant digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; loads the selected program's first state |
| mode | input | 1 | Program select at start: 0 increment, 1 add |
| up_sym | input | 2 | Upper-track symbol under the head |
| lo_sym | input | 2 | Lower-track symbol under the head |
| up_wr | output | 2 | Upper-track symbol to write |
| lo_wr | output | 2 | Lower-track symbol to write |
| move_right | output | 1 | Head direction after this step: 1 right, 0 left |
| halt | output | 1 | Program finished |

## Verification
The cases hardest to reach from the ports are the carry-state transitions, because the carry state can only be entered through a (1,1) pair in the no-carry state. The step-level stimulus first drives that pair. It then walks all four carry-state pairs and confirms the return to no-carry by the next step's result. The all-ones increment, which overflows into the left frame and must turn back, is reached with a full tape model driven by the block's own outputs. That same model flips `mode` right after every start pulse, so every run also shows that the captured program is kept.

// File: rtl/tape_prog_ctrl.sv
module tape_prog_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode,
  input  logic [1:0] up_sym,
  input  logic [1:0] lo_sym,
  output logic [1:0] up_wr,
  output logic [1:0] lo_wr,
  output logic       move_right,
  output logic       halt
);

  typedef enum logic [2:0] {
    IDLE, INC_CARRY, INC_RET, ADD_NC, ADD_C, HALTED
  } st_t;

  st_t st, nxt;

  logic up_frame, lo_frame, ub, lb;
  assign up_frame = up_sym[1];
  assign lo_frame = lo_sym[1];
  assign ub       = up_sym[0];
  assign lb       = lo_sym[0];

  assign up_wr = up_sym;

  always_comb begin
    nxt        = st;
    lo_wr      = lo_sym;
    move_right = 1'b0;
    halt       = 1'b0;
    case (st)
      INC_CARRY: begin
        if (lo_frame) begin
          move_right = 1'b1;
          nxt        = INC_RET;
        end else if (lb) begin
          lo_wr = 2'b00;
        end else begin
          lo_wr      = 2'b01;
          move_right = 1'b1;
          nxt        = INC_RET;
        end
      end
      INC_RET: begin
        if (lo_frame) begin
          halt = 1'b1;
          nxt  = HALTED;
        end else begin
          move_right = 1'b1;
        end
      end
      ADD_NC: begin
        if (up_frame) begin
          halt       = 1'b1;
          move_right = 1'b1;
          nxt        = HALTED;
        end else begin
          lo_wr = {1'b0, ub ^ lb};
          if (ub && lb) nxt = ADD_C;
        end
      end
      ADD_C: begin
        if (up_frame) begin
          halt       = 1'b1;
          move_right = 1'b1;
          nxt        = HALTED;
        end else if (!ub) begin
          lo_wr = {1'b0, ~lb};
          if (!lb) nxt = ADD_NC;
        end
      end
      HALTED: halt = 1'b1;
      default: ;
    endcase
    if (start) nxt = mode ? ADD_NC : INC_CARRY;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= IDLE;
    else        st <= nxt;

  a_r10_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !start) |=> halt);

  a_r10_start_leaves_halt: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st != HALTED && st != IDLE));

  a_r3_one_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (st == INC_CARRY && lo_sym == 2'b01 && !start) |=> st == INC_CARRY);

  a_r5_return_digit_right: assert property (@(posedge clk) disable iff (!rst_n)
    (st == INC_RET && !lo_frame) |-> (move_right && !halt && lo_wr == lo_sym));

  a_r6_add_digit_left: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ADD_NC || st == ADD_C) && !up_frame) |-> (!move_right && !halt));

  a_r2_program_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (st == ADD_NC || st == ADD_C)) |=> (st == ADD_NC || st == ADD_C || st == HALTED));

endmodule

// File: tb/tb_tape_prog_ctrl.sv
`timescale 1ns/1ps
module tb_tape_prog_ctrl;
  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [1:0] up_sym = 0, lo_sym = 0;
  logic [1:0] up_wr, lo_wr;
  logic move_right, halt;

  int checks = 0, errors = 0;

  tape_prog_ctrl dut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .up_sym(up_sym), .lo_sym(lo_sym), .up_wr(up_wr), .lo_wr(lo_wr),
    .move_right(move_right), .halt(halt));

  always #4 clk = ~clk;

  typedef struct {
    logic [1:0] uw, lw;
    logic mv, h;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (q.size() > 0) begin
    e = q.pop_front();
    chk({e.tag, " up_wr"}, up_wr, e.uw);
    chk({e.tag, " lo_wr"}, lo_wr, e.lw);
    chk({e.tag, " move_right"}, move_right, e.mv);
    chk({e.tag, " halt"}, halt, e.h);
  end

  // called just after a rising edge; applies one step and returns after the next edge
  task automatic step(logic [1:0] u, logic [1:0] l, logic [1:0] euw, logic [1:0] elw,
                      logic emv, logic eh, string tag);
    exp_t x;
    up_sym = u; lo_sym = l;
    x.uw = euw; x.lw = elw; x.mv = emv; x.h = eh; x.tag = tag;
    q.push_back(x);
    @(posedge clk); #1;
  endtask

  task automatic go(logic m);
    start = 1; mode = m;
    @(posedge clk); #1;
    start = 0; mode = ~m;
  endtask

  task automatic run_tape(logic m, int a, int b, int exp_lo, int exp_head, string tag);
    logic [1:0] ut[6], lt[6];
    int head = 4;
    int steps = 0;
    logic h = 0;
    int val = 0, uval = 0;
    ut[0] = 2'b10; lt[0] = 2'b10; ut[5] = 2'b11; lt[5] = 2'b11;
    for (int i = 0; i < 4; i++) begin
      ut[1+i] = {1'b0, 1'(a >> (3-i))};
      lt[1+i] = {1'b0, 1'(b >> (3-i))};
    end
    go(m);
    while (!h && steps < 64) begin
      up_sym = ut[head]; lo_sym = lt[head];
      @(negedge clk); #1;
      ut[head] = up_wr; lt[head] = lo_wr; h = halt;
      head = move_right ? head + 1 : head - 1;
      steps++;
      @(posedge clk); #1;
      if (head < 0 || head > 5) break;
    end
    chk({tag, " halted"}, h, 1);
    chk({tag, " head"}, head, exp_head);
    if (head >= 0 && head <= 5) begin
      for (int i = 0; i < 4; i++) begin
        val  = (val << 1) | int'(lt[1+i][0]);
        uval = (uval << 1) | int'(ut[1+i][0]);
      end
      chk({tag, " lower value"}, val, exp_lo);
      chk({tag, " R9 upper unchanged"}, uval, a);
    end
  endtask

  initial begin
    #(8*200000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    // R1 idle echo
    step(2'b01, 2'b10, 2'b01, 2'b10, 0, 0, "R1 idle");
    step(2'b11, 2'b00, 2'b11, 2'b00, 0, 0, "R1 idle");
    // R3 / R5 / R10 increment steps
    go(0);
    step(2'b11, 2'b01, 2'b11, 2'b00, 0, 0, "R3 one to zero left");
    step(2'b11, 2'b01, 2'b11, 2'b00, 0, 0, "R3 stays in first state");
    step(2'b11, 2'b00, 2'b11, 2'b01, 1, 0, "R3 zero to one right");
    step(2'b11, 2'b01, 2'b11, 2'b01, 1, 0, "R5 return digit");
    step(2'b00, 2'b10, 2'b00, 2'b10, 0, 1, "R5 return frame halt");
    step(2'b01, 2'b00, 2'b01, 2'b00, 0, 1, "R10 halt held");
    step(2'b10, 2'b01, 2'b10, 2'b01, 0, 1, "R10 halt held");
    // R4 frame in first state
    go(0);
    step(2'b01, 2'b11, 2'b01, 2'b11, 1, 0, "R4 frame in first state");
    step(2'b01, 2'b00, 2'b01, 2'b00, 1, 0, "R4 enters return");
    step(2'b01, 2'b11, 2'b01, 2'b11, 0, 1, "R4 return halts");
    // R6 / R7 / R8 add steps
    go(1);
    step(2'b00, 2'b00, 2'b00, 2'b00, 0, 0, "R6 nc 00");
    step(2'b00, 2'b01, 2'b00, 2'b01, 0, 0, "R6 nc 01");
    step(2'b01, 2'b00, 2'b01, 2'b01, 0, 0, "R6 nc 10");
    step(2'b01, 2'b01, 2'b01, 2'b00, 0, 0, "R6 nc 11 to carry");
    step(2'b01, 2'b00, 2'b01, 2'b00, 0, 0, "R7 c 10");
    step(2'b01, 2'b01, 2'b01, 2'b01, 0, 0, "R7 c 11");
    step(2'b00, 2'b01, 2'b00, 2'b00, 0, 0, "R7 c 01");
    step(2'b00, 2'b00, 2'b00, 2'b01, 0, 0, "R7 c 00 to nc");
    step(2'b01, 2'b01, 2'b01, 2'b00, 0, 0, "R7 back in nc");
    step(2'b01, 2'b01, 2'b01, 2'b01, 0, 0, "R7 carry again");
    step(2'b11, 2'b10, 2'b11, 2'b10, 1, 1, "R8 frame halt from carry");
    step(2'b11, 2'b11, 2'b11, 2'b11, 0, 1, "R10 halt held");
    go(1);
    step(2'b10, 2'b01, 2'b10, 2'b01, 1, 1, "R8 frame halt from nc");
    // R2 restart mid-run switches program
    go(1);
    step(2'b01, 2'b00, 2'b01, 2'b01, 0, 0, "R2 add running");
    go(0);
    step(2'b01, 2'b01, 2'b01, 2'b00, 0, 0, "R2 restart into increment");
    // R11 whole-tape runs (mode flipped after each start: R2)
    run_tape(0, 0, 6, 7, 4, "R11 inc 6");
    run_tape(0, 9, 5, 6, 4, "R11 inc 5");
    run_tape(0, 3, 15, 0, 4, "R11 inc 15 overflow");
    run_tape(1, 5, 3, 8, 1, "R11 add 5+3");
    run_tape(1, 15, 1, 0, 1, "R11 add 15+1");
    run_tape(1, 9, 6, 15, 1, "R11 add 9+6");
    run_tape(1, 12, 12, 8, 1, "R11 add 12+12");
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule